// File: doc/BRIEF.md
# Display Signature CRC Accumulator

This block folds the 24-bit pixel stream of a display pipeline into a running signature, so that test software can compare a whole frame against a known-good value without storing any pixels. Each cycle where the pixel strobe is high advances the accumulator by one step of the CRC that is selected in that cycle. Two CRCs are available: a 24-bit shift register with feedback from three of its own bits, and a 32-bit CRC with the common 0x04C11DB7 polynomial.

A capture can cover one frame or run freely. In single-frame use, software arms the block. The capture starts at the next frame-start pulse and stops at the matching frame-end pulse. A done flag is then raised, and the signature is frozen until the block is armed again. In free-running use, each frame adds to the same accumulator with no new seed. When free-run is turned off, the capture does not stop at once: it runs to the end of the frame in progress and then behaves as a finished single-frame capture.

Software reads the result through the palette read path. When signature readback is selected, the 24-bit read data carries the low signature bits in place of the palette word. The palette read address still advances on every read, as it does in normal palette reads.

Top module: `sig_crc_top`

## Requirements
- R1: After reset, `sig_out` is 0x00000001, `sig_done` is 0 and `pal_addr` is 0.
- R2: In an update cycle with `crc_sel`=0, the new signature is {8'h00, ({old[22:0], old[23]^old[3]^old[2]} ^ pix_data)}.
- R3: In an update cycle with `crc_sel`=1, the new signature is ({old[30:0],1'b0} ^ (old[31] ? 32'h04C11DB7 : 0)) ^ {8'h00, pix_data}.
- R4: A capture start loads 0x00000001 into the signature and ignores the pixel of that cycle. Outside a capture, and in cycles with `pix_valid`=0, the signature does not change.
- R5: A pulse on `arm` while idle or done clears `sig_done`. The capture then starts at the next `frame_start`. A `frame_end` during a capture with `free_run`=0 ends the capture, and `sig_done` reads 1 from the next cycle. The signature then holds until a new capture starts.
- R6: With `free_run`=1, a `frame_start` outside a capture starts one without `arm`. Later frame boundaries neither reseed the signature nor set `sig_done`.
- R7: Clearing `free_run` during a frame lets accumulation continue up to that frame's `frame_end`. The capture then stops and `sig_done` is set.
- R8: `rd_data` equals `sig_out[23:0]` when `rd_sel`=1 and equals `pal_rdata` when `rd_sel`=0, within the same cycle.
- R9: `pal_addr_wr` loads `pal_addr_in` into `pal_addr` and takes priority. Otherwise each `pal_rd` adds 1 modulo 2^ADDR_W, whatever the value of `rd_sel`.
- R10: `crc_sel` takes effect in the cycle it is applied, so a capture may mix both CRCs step by step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_data | input | 24 | Pixel word |
| pix_valid | input | 1 | Pixel strobe; one update per high cycle |
| frame_start | input | 1 | One-cycle pulse before the first pixel of a frame |
| frame_end | input | 1 | One-cycle pulse at the close of a frame |
| crc_sel | input | 1 | 0: 24-bit feedback CRC, 1: 32-bit polynomial CRC |
| free_run | input | 1 | Continuous capture across frames |
| arm | input | 1 | Pulse that requests a single-frame capture |
| rd_sel | input | 1 | Return the signature on the palette read path |
| pal_rd | input | 1 | Palette read strobe |
| pal_addr_wr | input | 1 | Load strobe for the palette address |
| pal_addr_in | input | ADDR_W | Palette address value to load |
| pal_rdata | input | 24 | Word read from the palette storage |
| sig_out | output | 32 | Full signature value |
| sig_done | output | 1 | Single-frame capture finished |
| rd_data | output | 24 | Palette read data after the signature select |
| pal_addr | output | ADDR_W | Palette read address |

## Verification
The checks assume that `frame_start` and `frame_end` never arrive in the same cycle. They also assume that `frame_start` never comes with `pix_valid` high, because the pixel in a start cycle is dropped by design. The stimulus builds every frame as a start pulse with the strobe low, then a body of random pixels, strobes, read strobes and CRC selections, then an end pulse, so both pulses never coincide. `arm` and `free_run` changes land between frames, except in the directed case where `free_run` is cleared in the middle of a frame.

// File: rtl/sig_crc_pkg.sv
// Shared widths, constants and capture state encoding for the signature block.
package sig_crc_pkg;
    localparam int PIX_W  = 24;
    localparam int SIG_W  = 32;
    localparam int PAD_W  = SIG_W - PIX_W;
    localparam logic [SIG_W-1:0] POLY32 = 32'h04C1_1DB7;
    localparam logic [SIG_W-1:0] SEED   = 32'h0000_0001;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2,
        CAP_DONE  = 2'd3
    } cap_state_t;
endpackage

// File: rtl/sig_crc_engine.sv
// Next-state logic of the signature. It is purely combinational.
// Assumes: cur holds the present signature; the selected CRC is applied to it.
module sig_crc_engine
    import sig_crc_pkg::*;
(
    input  logic [SIG_W-1:0] cur,
    input  logic [PIX_W-1:0] pix,
    input  logic             sel,
    output logic [SIG_W-1:0] nxt
);
    logic [PIX_W-1:0] short_nxt;
    logic [SIG_W-1:0] long_nxt;

    // 24-bit shift with a feedback bit formed from three taps
    always_comb begin
        short_nxt = {cur[PIX_W-2:0], cur[PIX_W-1] ^ cur[3] ^ cur[2]} ^ pix;
    end

    // 32-bit shift with conditional polynomial, then data fold
    always_comb begin
        long_nxt = {cur[SIG_W-2:0], 1'b0} ^ (cur[SIG_W-1] ? POLY32 : '0);
        long_nxt = long_nxt ^ {{PAD_W{1'b0}}, pix};
    end

    // Pick the CRC requested in this cycle
    always_comb begin
        nxt = sel ? long_nxt : {{PAD_W{1'b0}}, short_nxt};
    end
endmodule

// File: rtl/sig_crc_ctrl.sv
// Capture sequencer: arming, frame-bounded or free-running capture, and done flag.
// Assumes: frame_start and frame_end are one-cycle pulses that never coincide.
module sig_crc_ctrl
    import sig_crc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic frame_end,
    input  logic pix_valid,
    input  logic free_run,
    input  logic arm,
    output logic load_seed,
    output logic upd_en,
    output logic done
);
    cap_state_t state;
    logic       start;

    // A capture begins at a frame start when armed or when free-running outside a run
    always_comb begin
        start     = frame_start &&
                    ((state == CAP_ARMED) || (free_run && (state != CAP_RUN)));
        load_seed = start;
        upd_en    = !start && (state == CAP_RUN) && pix_valid;
    end

    // Advance the capture state and track the done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
            done  <= 1'b0;
        end else if (start) begin
            state <= CAP_RUN;
            done  <= 1'b0;
        end else if (state == CAP_RUN) begin
            if (frame_end && !free_run) begin
                state <= CAP_DONE;
                done  <= 1'b1;
            end
        end else if (arm && (state != CAP_ARMED)) begin
            state <= CAP_ARMED;
            done  <= 1'b0;
        end
    end
endmodule

// File: rtl/sig_crc_rdport.sv
// Palette read path: signature substitution and the auto-incrementing read address.
// Assumes: one pal_rd strobe per read access.
module sig_crc_rdport
    import sig_crc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel,
    input  logic              pal_rd,
    input  logic              pal_addr_wr,
    input  logic [ADDR_W-1:0] pal_addr_in,
    input  logic [PIX_W-1:0]  pal_rdata,
    input  logic [PIX_W-1:0]  sig_low,
    output logic [PIX_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] pal_addr
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    // Substitute the signature for the palette word when selected
    always_comb begin
        rd_data = rd_sel ? sig_low : pal_rdata;
    end

    // Load the address, or step it on each read, whichever source is read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_addr <= '0;
        end else if (pal_addr_wr) begin
            pal_addr <= pal_addr_in;
        end else if (pal_rd) begin
            pal_addr <= pal_addr + ADDR_ONE;
        end
    end
endmodule

// File: rtl/sig_crc_top.sv
// Display signature accumulator: wraps the sequencer, CRC engine and read path.
// Assumes: no pixel strobe in a frame-start cycle (that pixel is not counted).
module sig_crc_top
    import sig_crc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [23:0]       pix_data,
    input  logic              pix_valid,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              crc_sel,
    input  logic              free_run,
    input  logic              arm,
    input  logic              rd_sel,
    input  logic              pal_rd,
    input  logic              pal_addr_wr,
    input  logic [ADDR_W-1:0] pal_addr_in,
    input  logic [23:0]       pal_rdata,
    output logic [31:0]       sig_out,
    output logic              sig_done,
    output logic [23:0]       rd_data,
    output logic [ADDR_W-1:0] pal_addr
);
    logic             load_seed;
    logic             upd_en;
    logic [SIG_W-1:0] acc;
    logic [SIG_W-1:0] acc_nxt;

    sig_crc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .pix_valid   (pix_valid),
        .free_run    (free_run),
        .arm         (arm),
        .load_seed   (load_seed),
        .upd_en      (upd_en),
        .done        (sig_done)
    );

    sig_crc_engine u_engine (
        .cur (acc),
        .pix (pix_data),
        .sel (crc_sel),
        .nxt (acc_nxt)
    );

    // Signature register: seed at capture start, advance on strobed pixels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= SEED;
        end else if (load_seed) begin
            acc <= SEED;
        end else if (upd_en) begin
            acc <= acc_nxt;
        end
    end

    sig_crc_rdport #(.ADDR_W(ADDR_W)) u_rdport (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_sel      (rd_sel),
        .pal_rd      (pal_rd),
        .pal_addr_wr (pal_addr_wr),
        .pal_addr_in (pal_addr_in),
        .pal_rdata   (pal_rdata),
        .sig_low     (acc[PIX_W-1:0]),
        .rd_data     (rd_data),
        .pal_addr    (pal_addr)
    );

    // Drive the full signature output
    always_comb begin
        sig_out = acc;
    end
endmodule

// File: rtl/sig_crc_chk.sv
// Property checker for sig_crc_top, attached with bind below.
// Assumes: it only observes; all ports are inputs.
module sig_crc_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              frame_start,
    input logic              frame_end,
    input logic              arm,
    input logic              pal_rd,
    input logic              pal_addr_wr,
    input logic [31:0]       sig_out,
    input logic              sig_done,
    input logic [ADDR_W-1:0] pal_addr
);
    // R1
    reset_seed_chk: assert property (@(posedge clk)
        !rst_n |=> (sig_out == 32'h1) && !sig_done && (pal_addr == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_valid && !frame_start) |=> $stable(sig_out));

    // R5
    done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_done && !arm && !frame_start) |=> (sig_done && $stable(sig_out)));

    // R5
    done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_done) |-> $past(frame_end));

    // R5
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !frame_end) |=> !sig_done);

    // R9
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_rd && !pal_addr_wr) |=> (pal_addr == $past(pal_addr) + 1'b1));

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pal_rd && !pal_addr_wr) |=> $stable(pal_addr));
endmodule

bind sig_crc_top sig_crc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid   (pix_valid),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .arm         (arm),
    .pal_rd      (pal_rd),
    .pal_addr_wr (pal_addr_wr),
    .sig_out     (sig_out),
    .sig_done    (sig_done),
    .pal_addr    (pal_addr)
);

// File: tb/sig_crc_top_test.sv
`timescale 1ns/1ps
// Self-checking bench: reference model from the requirements, random frames plus directed cases.
module sig_crc_top_test;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [23:0]   pix_data = '0;
    logic          pix_valid = 1'b0;
    logic          frame_start = 1'b0;
    logic          frame_end = 1'b0;
    logic          crc_sel = 1'b0;
    logic          free_run = 1'b0;
    logic          arm = 1'b0;
    logic          rd_sel = 1'b0;
    logic          pal_rd = 1'b0;
    logic          pal_addr_wr = 1'b0;
    logic [AW-1:0] pal_addr_in = '0;
    logic [23:0]   pal_rdata = '0;
    logic [31:0]   sig_out;
    logic          sig_done;
    logic [23:0]   rd_data;
    logic [AW-1:0] pal_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state: 0 idle, 1 armed, 2 run, 3 done
    logic [31:0]   m_acc = 32'h1;
    int            m_st = 0;
    logic          m_done = 1'b0;
    logic [AW-1:0] m_addr = '0;
    string         m_tag = "R1";

    sig_crc_top #(.ADDR_W(AW)) uut (.*);

    always #10 clk = ~clk;

    function automatic logic [31:0] f24(input logic [31:0] a, input logic [23:0] d);
        return {8'h00, {a[22:0], a[23] ^ a[3] ^ a[2]} ^ d};
    endfunction

    function automatic logic [31:0] f32(input logic [31:0] a, input logic [23:0] d);
        return ({a[30:0], 1'b0} ^ (a[31] ? 32'h04C11DB7 : 32'h0)) ^ {8'h00, d};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: update model from the driven inputs, then compare at the falling edge
    task automatic tick();
        bit start;
        @(posedge clk);
        if (!rst_n) begin
            m_acc = 32'h1; m_st = 0; m_done = 0; m_addr = '0; m_tag = "R1";
        end else begin
            start = frame_start && (m_st == 1 || (free_run && m_st != 2));
            if (start) begin
                m_acc = 32'h1; m_st = 2; m_done = 0; m_tag = "R4";
            end else if (m_st == 2) begin
                if (pix_valid) begin
                    m_acc = crc_sel ? f32(m_acc, pix_data) : f24(m_acc, pix_data);
                    m_tag = crc_sel ? "R3" : "R2";
                end
                if (frame_end && !free_run) begin
                    m_st = 3; m_done = 1;
                end
            end else if (arm && m_st != 1) begin
                m_st = 1; m_done = 0;
            end
            if (pal_addr_wr) m_addr = pal_addr_in;
            else if (pal_rd) m_addr = m_addr + 1'b1;
        end
        @(negedge clk);
        chk(m_tag, sig_out, m_acc);
        chk("R5", {31'b0, sig_done}, {31'b0, m_done});
        chk("R9", {24'b0, pal_addr}, {24'b0, m_addr});
        chk("R8", {8'b0, rd_data}, {8'b0, rd_sel ? m_acc[23:0] : pal_rdata});
    endtask

    task automatic idle_inputs();
        pix_valid = 0; frame_start = 0; frame_end = 0; arm = 0;
        pal_rd = 0; pal_addr_wr = 0;
    endtask

    task automatic pix(input logic [23:0] d, input logic sel, input logic v);
        idle_inputs(); pix_data = d; crc_sel = sel; pix_valid = v; tick();
    endtask

    task automatic fstart();
        idle_inputs(); frame_start = 1; tick();
    endtask

    task automatic fend();
        idle_inputs(); frame_end = 1; tick();
    endtask

    task automatic do_arm();
        idle_inputs(); arm = 1; tick();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // watchdog: a hung run counts as one failure
    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] e;
        void'($urandom(32'd4242));
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick();
        // R1 reset state
        chk("R1", sig_out, 32'h1);
        chk("R1", {31'b0, sig_done}, 32'h0);
        chk("R1", {24'b0, pal_addr}, 32'h0);
        rst_n = 1;

        // R4: pixels outside a capture are ignored
        pix(24'hABCDEF, 0, 1);
        chk("R4", sig_out, 32'h1);

        // R5, R2: single frame in the 24-bit mode
        do_arm();
        pix(24'h111111, 0, 1);
        chk("R5", sig_out, 32'h1);
        fstart();
        chk("R4", sig_out, 32'h1);
        pix(24'h123456, 0, 1);
        e = f24(32'h1, 24'h123456);
        chk("R2", sig_out, e);
        pix(24'h777777, 0, 0);
        chk("R4", sig_out, e);
        pix(24'h800008, 0, 1);
        e = f24(e, 24'h800008);
        chk("R2", sig_out, e);
        fend();
        chk("R5", {31'b0, sig_done}, 32'h1);
        pix(24'h55AA55, 1, 1);
        chk("R5", sig_out, e);
        do_arm();
        chk("R5", {31'b0, sig_done}, 32'h0);

        // R3, R10: 32-bit mode then a switch back within a frame
        fstart();
        pix(24'hFF0000, 1, 1);
        e = f32(32'h1, 24'hFF0000);
        chk("R3", sig_out, e);
        for (int i = 0; i < 30; i++) begin
            pix(24'h00F00F, 1, 1);
            e = f32(e, 24'h00F00F);
        end
        chk("R3", sig_out, e);
        pix(24'h0A0B0C, 0, 1);
        e = f24(e, 24'h0A0B0C);
        chk("R10", sig_out, e);
        fend();

        // R6: free run spans frames without reseed or done
        free_run = 1;
        fstart();
        pix(24'h000123, 1, 1);
        e = f32(32'h1, 24'h000123);
        fend();
        chk("R6", {31'b0, sig_done}, 32'h0);
        fstart();
        chk("R6", sig_out, e);
        pix(24'h456000, 1, 1);
        e = f32(e, 24'h456000);
        chk("R6", sig_out, e);
        // R7: clearing free run mid-frame runs to frame end
        free_run = 0;
        pix(24'h000777, 0, 1);
        e = f24(e, 24'h000777);
        chk("R7", sig_out, e);
        chk("R7", {31'b0, sig_done}, 32'h0);
        fend();
        chk("R7", {31'b0, sig_done}, 32'h1);
        chk("R7", sig_out, e);

        // R8, R9: readback and address wrap
        idle_inputs(); pal_addr_wr = 1; pal_addr_in = 8'hFE; rd_sel = 1; tick();
        idle_inputs(); pal_rd = 1; pal_rdata = 24'h0F0F0F; tick();
        chk("R8", {8'b0, rd_data}, {8'b0, e[23:0]});
        idle_inputs(); pal_rd = 1; tick();
        chk("R9", {24'b0, pal_addr}, 32'h0);
        idle_inputs(); pal_rd = 1; pal_addr_wr = 1; pal_addr_in = 8'h40; tick();
        chk("R9", {24'b0, pal_addr}, 32'h40);
        rd_sel = 0; pal_rdata = 24'h0C0FFE; #1;
        chk("R8", {8'b0, rd_data}, 32'h0C0FFE);

        // random frames
        for (int f = 0; f < 60; f++) begin
            free_run = ($urandom % 4) == 0;
            if (($urandom % 2) == 0) do_arm();
            fstart();
            for (int c = 0; c < 10 + ($urandom % 40); c++) begin
                idle_inputs();
                pix_data = 24'($urandom);
                pix_valid = ($urandom % 4) != 0;
                crc_sel = ($urandom % 3) == 0;
                rd_sel = $urandom % 2;
                pal_rd = ($urandom % 5) == 0;
                pal_addr_wr = ($urandom % 17) == 0;
                pal_addr_in = AW'($urandom);
                pal_rdata = 24'($urandom);
                if (c == 5 && ($urandom % 3) == 0) free_run = 0;
                tick();
            end
            fend();
            pix(24'($urandom), $urandom % 2, 1);
        end
        summary();
    end
endmodule